// File: doc/BRIEF.md
# Three-Wire Character Display Write Driver

This block writes bytes to a character display controller running in its 4-bit, write-only mode, using only three wires: a shift clock, a serial data line and a latch strobe. The wires feed an external 8-bit serial-in, parallel-out register with an output latch. The register's latched outputs drive the display's four upper data lines, its register-select line and its enable strobe. The read/write line is held low on the board, so the display is never read.

Bytes come in over a valid/ready stream, each tagged as instruction or character data. Because the enable strobe is one bit of the shifted word, every nibble takes three complete shift-and-latch frames: enable low, enable high, enable low, with the nibble and register-select held constant across all three. The upper nibble goes first, then the lower. After the last frame the block waits out the display's execution time before it takes the next byte. Back-pressure rule: a byte is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the execution wait has ended. A sender may hold `in_valid` high with a new byte at any time, and that byte is taken only once `in_ready` returns.

Top module: `lcd_serial_drv`

## Requirements
- R1: After reset, `in_ready` is 1 and `sclk`, `sdata` and `latch` are 0.
- R2: Each latched word carries the nibble in bits 3:0 (bit 0 drives display data line 4, bit 3 drives line 7), register-select in bit 4, the enable strobe in bit 5, and 0 in bits 7:6.
- R3: Each frame gives exactly 8 rising `sclk` edges, bit 7 first. `sdata` is steady at each rising edge. After the eighth bit, `latch` is high for exactly one cycle while `sclk` is low.
- R4: For every byte, the three frames of the upper nibble (byte bits 7:4) are latched before the three frames of the lower nibble.
- R5: Each nibble is sent as three frames with enable bits 0, 1, 0, and the nibble and register-select are identical in all three.
- R6: Register-select is 1 when `in_is_data` was 1 at acceptance, and 0 for an instruction.
- R7: A byte is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low from the accepting edge until the execution wait ends. A held `in_valid` is taken exactly once per `in_ready` window.
- R8: For data bytes and ordinary instructions, `in_ready` returns no earlier than SHORT_WAIT and no later than SHORT_WAIT+4 cycles after the last latch pulse of the byte.
- R9: Instruction bytes 0x01 (clear) and 0x02/0x03 (home) get LONG_WAIT instead of SHORT_WAIT, with the same bounds. A data byte of value 0x01 gets SHORT_WAIT.
- R10: Each high phase of `sclk` lasts exactly CLK_DIV system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered on the stream |
| in_ready | output | 1 | Block can take a byte this cycle |
| in_is_data | input | 1 | 1 = character data, 0 = instruction |
| in_byte | input | 8 | Byte to write |
| sclk | output | 1 | Shift clock to the external register |
| sdata | output | 1 | Serial data, bit 7 of each word first |
| latch | output | 1 | One-cycle strobe that copies the shifted word to the outputs |

## Verification
The in-RTL assertions check the cycle-level rules on every cycle. These are: the latch strobe is a single cycle and never coincides with a high shift clock; serial data is steady when the shift clock rises; no clock activity happens while the shifter is idle; ready drops after every accepted byte and no frame starts while ready is high; and the execution counter stays expired until it is reloaded. The bench rebuilds the external register's latched words and checks things the assertions cannot see. These are the word layout, upper-before-lower nibble order, the 0-1-0 enable pattern with data held, register-select from the tag, the shift-clock high width, the short and long waits (including a data byte with the clear value), and in-order delivery of a byte held waiting behind a busy block.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int WORD_W  = 8;
  localparam int NIB_W   = 4;
  localparam int RS_BIT  = 4;
  localparam int EN_BIT  = 5;
  localparam int FRAMES  = 6;
  localparam int FRAME_W = $clog2(FRAMES);

  function automatic logic [WORD_W-1:0] pack_word(input logic [NIB_W-1:0] nib,
                                                  input logic rs, input logic en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[NIB_W-1:0] = nib;
    w[RS_BIT]    = rs;
    w[EN_BIT]    = en;
    return w;
  endfunction

  function automatic logic needs_long(input logic is_data, input logic [WORD_W-1:0] b);
    return !is_data && (b == 8'h01 || b[7:1] == 7'h01);
  endfunction
endpackage

// File: rtl/lcd_frame_shifter.sv
module lcd_frame_shifter #(
  parameter int CLK_DIV = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] word,
  output logic       busy,
  output logic       done,
  output logic       sclk,
  output logic       sdata,
  output logic       latch
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);

  typedef enum logic [1:0] {SH_IDLE, SH_BITS, SH_LATCH} sh_state_e;
  sh_state_e   st;
  logic [7:0]  sh;
  logic [2:0]  bit_n;
  logic        half;
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= SH_IDLE; sh <= '0; bit_n <= '0; half <= 1'b0; cnt <= '0;
    end else begin
      case (st)
        SH_IDLE: if (start) begin
          sh <= word; bit_n <= '0; half <= 1'b0; cnt <= '0; st <= SH_BITS;
        end
        SH_BITS: begin
          if (cnt == DIV_LAST) begin
            cnt <= '0;
            if (!half) begin
              half <= 1'b1;
            end else begin
              half <= 1'b0;
              sh   <= {sh[6:0], 1'b0};
              if (bit_n == 3'd7) st <= SH_LATCH;
              else bit_n <= bit_n + 3'd1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  assign sclk  = (st == SH_BITS) && half;
  assign sdata = sh[7];
  assign latch = (st == SH_LATCH);
  assign busy  = (st != SH_IDLE);
  assign done  = latch;

  a_r3_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> !latch);
  a_r3_latch_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
    latch |-> !sclk);
  a_r3_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sclk && !latch));
endmodule

// File: rtl/lcd_exec_timer.sv
module lcd_exec_timer #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= len;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  a_r8_stays_expired: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && !load) |=> zero);
  a_r8_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (load && len != '0) |=> !zero);
endmodule

// File: rtl/lcd_byte_seq.sv
module lcd_byte_seq
  import lcd_drv_pkg::*;
#(
  parameter int CNT_W      = 20,
  parameter int SHORT_WAIT = 10000,
  parameter int LONG_WAIT  = 410000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_is_data,
  input  logic [7:0]       in_byte,
  output logic             frm_start,
  output logic [7:0]       frm_word,
  input  logic             frm_done,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_len,
  input  logic             tmr_zero
);
  typedef enum logic [1:0] {Q_IDLE, Q_ISSUE, Q_FRAME, Q_EXEC} q_state_e;
  q_state_e           st;
  logic [7:0]         byte_q;
  logic               rs_q;
  logic               long_q;
  logic [FRAME_W-1:0] fi;
  logic               upper;
  logic               en_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= Q_IDLE; byte_q <= '0; rs_q <= 1'b0; long_q <= 1'b0; fi <= '0;
    end else begin
      case (st)
        Q_IDLE: if (in_valid) begin
          byte_q <= in_byte;
          rs_q   <= in_is_data;
          long_q <= needs_long(in_is_data, in_byte);
          fi     <= '0;
          st     <= Q_ISSUE;
        end
        Q_ISSUE: st <= Q_FRAME;
        Q_FRAME: if (frm_done) begin
          if (fi == FRAME_W'(FRAMES - 1)) st <= Q_EXEC;
          else begin
            fi <= fi + 1'b1;
            st <= Q_ISSUE;
          end
        end
        Q_EXEC: if (tmr_zero) st <= Q_IDLE;
        default: st <= Q_IDLE;
      endcase
    end
  end

  // frames 0..2 carry the upper nibble, 3..5 the lower; enable high in the middle one
  assign upper     = (fi < FRAME_W'(3));
  assign en_bit    = (fi == FRAME_W'(1)) || (fi == FRAME_W'(4));
  assign frm_word  = pack_word(upper ? byte_q[7:4] : byte_q[3:0], rs_q, en_bit);
  assign frm_start = (st == Q_ISSUE);
  assign in_ready  = (st == Q_IDLE);
  assign tmr_load  = (st == Q_FRAME) && frm_done && (fi == FRAME_W'(FRAMES - 1));
  assign tmr_len   = long_q ? CNT_W'(LONG_WAIT) : CNT_W'(SHORT_WAIT);

  a_r7_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  a_r7_no_frame_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> !in_ready);
  a_r8_ready_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(tmr_zero));
endmodule

// File: rtl/lcd_serial_drv.sv
module lcd_serial_drv
  import lcd_drv_pkg::*;
#(
  parameter int CLK_DIV    = 16,
  parameter int SHORT_WAIT = 10000,
  parameter int LONG_WAIT  = 410000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_is_data,
  input  logic [7:0] in_byte,
  output logic       sclk,
  output logic       sdata,
  output logic       latch
);
  localparam int MAX_WAIT = (LONG_WAIT > SHORT_WAIT) ? LONG_WAIT : SHORT_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1) + 1;

  logic             frm_start, frm_done, frm_busy;
  logic [7:0]       frm_word;
  logic             tmr_load, tmr_zero;
  logic [CNT_W-1:0] tmr_len;

  lcd_byte_seq #(.CNT_W(CNT_W), .SHORT_WAIT(SHORT_WAIT), .LONG_WAIT(LONG_WAIT)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_is_data(in_is_data), .in_byte(in_byte),
    .frm_start(frm_start), .frm_word(frm_word), .frm_done(frm_done),
    .tmr_load(tmr_load), .tmr_len(tmr_len), .tmr_zero(tmr_zero)
  );

  lcd_frame_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(frm_start), .word(frm_word),
    .busy(frm_busy), .done(frm_done), .sclk(sclk), .sdata(sdata), .latch(latch)
  );

  lcd_exec_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(tmr_len), .zero(tmr_zero)
  );

  a_r7_start_needs_idle_shifter: assert property (@(posedge clk) disable iff (!rst_n)
    frm_start |-> !frm_busy);
endmodule

// File: tb/lcd_serial_drv_bench.sv
module lcd_serial_drv_bench;
  localparam int DIV = 2;
  localparam int SW  = 40;
  localparam int LW  = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_is_data = 1'b0;
  logic [7:0] in_byte = '0;
  logic in_ready, sclk, sdata, latch;

  always #2 clk = ~clk;

  lcd_serial_drv #(.CLK_DIV(DIV), .SHORT_WAIT(SW), .LONG_WAIT(LW)) u_lcd_serial_drv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_is_data(in_is_data), .in_byte(in_byte),
    .sclk(sclk), .sdata(sdata), .latch(latch)
  );

  // external register model
  int cyc = 0, widx = 0, lat_cyc = 0, ecnt = 0, hcnt = 0, hmin = 9999, hmax = 0;
  logic [7:0] sr = '0;
  logic [7:0] words [0:127];
  int         edges [0:127];
  logic       sclk_d = 1'b0;

  always @(posedge clk) begin
    cyc    <= cyc + 1;
    sclk_d <= sclk;
    if (rst_n) begin
      if (sclk && !sclk_d) begin
        sr   <= {sr[6:0], sdata};
        ecnt <= ecnt + 1;
      end
      if (sclk) hcnt <= hcnt + 1;
      if (!sclk && sclk_d) begin
        if (hcnt < hmin) hmin <= hcnt;
        if (hcnt > hmax) hmax <= hcnt;
        hcnt <= 0;
      end
      if (latch) begin
        words[widx] <= sr;
        edges[widx] <= ecnt;
        ecnt    <= 0;
        widx    <= widx + 1;
        lat_cyc <= cyc;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic isd, input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_is_data = isd; in_byte = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(!in_ready, "R7 ready low after take", in_ready, 0);
  endtask

  task automatic wait_ready(output int gap);
    while (!in_ready) @(negedge clk);
    gap = cyc - lat_cyc;
  endtask

  task automatic check_frames(input int base, input logic isd, input logic [7:0] b);
    for (int f = 0; f < 6; f++) begin
      logic [3:0] nib;
      logic [7:0] exp;
      nib = (f < 3) ? b[7:4] : b[3:0];          // R4 upper first
      exp = {2'b00, (f == 1 || f == 4), isd, nib}; // R2 R5 R6
      check(words[base+f] == exp, "R2/R4/R5/R6 latched word", words[base+f], exp);
      check(edges[base+f] == 8, "R3 edges per frame", edges[base+f], 8);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check({sclk, sdata, latch} == 3'b000, "R1 serial lines idle", {sclk, sdata, latch}, 0);
  endtask

  task automatic t_one(input logic isd, input logic [7:0] b, input int wait_len, input string tag);
    int base, gap;
    base = widx;
    send_byte(isd, b);
    wait_ready(gap);
    check(widx - base == 6, "R7 six frames per byte", widx - base, 6);
    check_frames(base, isd, b);
    if (gap < wait_len || gap > wait_len + 4) begin
      n_chk++; n_bad++;
      $display("FAIL %s wait actual=%0d expected=%0d", tag, gap, wait_len);
    end else n_chk++;
  endtask

  task automatic t_backpressure();
    int base, gap;
    base = widx;
    send_byte(1'b1, 8'h5A);
    send_byte(1'b0, 8'hC3);   // held valid while busy
    wait_ready(gap);
    check(widx - base == 12, "R7 held byte taken once", widx - base, 12);
    check_frames(base, 1'b1, 8'h5A);
    check_frames(base + 6, 1'b0, 8'hC3);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_one(1'b1, 8'h41, SW, "R8 data byte");
    t_one(1'b0, 8'h28, SW, "R8 plain instruction");
    t_one(1'b0, 8'h01, LW, "R9 clear instruction");
    t_one(1'b0, 8'h03, LW, "R9 home instruction");
    t_one(1'b0, 8'h02, LW, "R9 home instruction 02");
    t_one(1'b1, 8'h01, SW, "R9 data 0x01 is short");
    t_one(1'b1, 8'hF0, SW, "R8 data F0");
    t_backpressure();
    check(hmin == DIV && hmax == DIV, "R10 sclk high width", hmax, DIV);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end
endmodule